// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block is a purely combinational 8-by-8 multistage network. It is built from three stages of four 2x2 switches, with a perfect-shuffle permutation of the eight lanes ahead of every stage. Each source lane may present one message: a valid bit, a 3-bit destination and a data word. The network sets every switch from the destination bits and delivers each message that gets through to the output lane equal to its destination.

A stage can offer only one path per switch output. Two messages that ask for the same switch output at the same stage collide, even when their final destinations differ. The message on the switch's upper input wins. The loser is dropped and reported on a per-source blocked flag for that cycle, with no retry and no buffering. The cross/pass setting of all twelve switches is exposed for inspection.

Lane count and data width are parameters. The lane count must be a power of two.

Top module: `omega_route`

## Requirements
- R1: Every delivered message appears on output lane `dlv_valid[j]` with j equal to its 3-bit destination field (`req_dest[3*i+2:3*i]` for source i), and its data word is unchanged.
- R2: Ahead of each stage, lane p moves to lane {p[1:0], p[2]}, a one-bit left rotation of its index.
- R3: At stage k (k = 0, 1, 2), a message leaves its switch on the upper output (even lane) when destination bit 2-k is 0, and on the lower output (odd lane) when that bit is 1.
- R4: When both inputs of a switch carry valid messages that want the same output, the upper-input message proceeds and the lower-input message is dropped, with its source's `req_blocked` bit set.
- R5: `req_blocked[i]` is never set for an idle source. Every valid source is either delivered exactly once or blocked, never both.
- R6: `sw_cross[4*k+s]` gives the setting of switch s of stage k, where 1 means cross-over and 0 means pass-through. A switch with no valid input is pass-through. Otherwise the setting follows the message on the upper input if one is present, or else the lower one.
- R7: Source 2 to destination 7 together with source 6 to destination 4 collide. Source 6 is blocked and source 2 reaches output 7.
- R8: A lone valid message is always delivered, from any source to any destination.
- R9: A cyclic shift (source i to destination (i+c) mod 8, all sources valid) is delivered with no blocking.
- R10: With no valid input, every output is invalid, no source is blocked, and all switches are pass-through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid | input | PORTS | Per-source message present |
| req_dest | input | PORTS*SB | Per-source destination, 3 bits per lane |
| req_data | input | PORTS*DW | Per-source data word |
| dlv_valid | output | PORTS | Per-output message delivered |
| dlv_data | output | PORTS*DW | Per-output data word (zero when invalid) |
| req_blocked | output | PORTS | Per-source lost contention this cycle |
| sw_cross | output | SB*PORTS/2 | Switch settings, stage-major, 1 = cross-over |

## Verification
A switch set the wrong way shows up at once in the same evaluation. Either a data word lands on the wrong output lane, or two deliveries merge into one with a blocked flag raised where none was due. Either way the outputs disagree with a path-tracing model in the bench. A wrong winner in contention flips one source's blocked flag and swaps which payload reaches the output, so the directed collision pair and the per-switch setting vector expose it within a single vector. There is no state, so no error can stay hidden beyond the cycle in which the faulty routing occurs.

// File: rtl/omega_route.sv
module omega_route #(
  parameter int PORTS = 8,
  parameter int DW    = 16,
  localparam int SB   = $clog2(PORTS),
  localparam int HALF = PORTS / 2
) (
  input  logic [PORTS-1:0]    req_valid,
  input  logic [PORTS*SB-1:0] req_dest,
  input  logic [PORTS*DW-1:0] req_data,
  output logic [PORTS-1:0]    dlv_valid,
  output logic [PORTS*DW-1:0] dlv_data,
  output logic [PORTS-1:0]    req_blocked,
  output logic [SB*HALF-1:0]  sw_cross
);

  always_comb begin : route
    logic [PORTS-1:0] v, sv, blk;
    logic [SB-1:0]    d   [PORTS];
    logic [SB-1:0]    sd  [PORTS];
    logic [SB-1:0]    src [PORTS];
    logic [SB-1:0]    ssrc[PORTS];
    logic [DW-1:0]    x   [PORTS];
    logic [DW-1:0]    sx  [PORTS];
    logic [SB-1:0]    r;
    logic             bu, bl, cr;
    blk      = '0;
    sw_cross = '0;
    dlv_data = '0;
    sv       = '0;
    for (int i = 0; i < PORTS; i++) begin
      v[i]    = req_valid[i];
      d[i]    = req_dest[i*SB +: SB];
      x[i]    = req_data[i*DW +: DW];
      src[i]  = SB'(i);
      sd[i]   = '0;
      sx[i]   = '0;
      ssrc[i] = '0;
    end
    for (int k = 0; k < SB; k++) begin
      for (int i = 0; i < PORTS; i++) begin
        r       = SB'(((i << 1) | (i >> (SB - 1))) % PORTS);
        sv[r]   = v[i];
        sd[r]   = d[i];
        sx[r]   = x[i];
        ssrc[r] = src[i];
      end
      for (int s = 0; s < HALF; s++) begin
        bu = sd[2*s][SB-1-k];
        bl = sd[2*s+1][SB-1-k];
        cr = sv[2*s] ? bu : (sv[2*s+1] ? ~bl : 1'b0);
        if (sv[2*s] && sv[2*s+1] && (bu == bl)) begin
          blk[ssrc[2*s+1]] = 1'b1;
          sv[2*s+1]        = 1'b0;
        end
        sw_cross[k*HALF+s] = cr;
        v[2*s]     = cr ? sv[2*s+1]   : sv[2*s];
        v[2*s+1]   = cr ? sv[2*s]     : sv[2*s+1];
        d[2*s]     = cr ? sd[2*s+1]   : sd[2*s];
        d[2*s+1]   = cr ? sd[2*s]     : sd[2*s+1];
        x[2*s]     = cr ? sx[2*s+1]   : sx[2*s];
        x[2*s+1]   = cr ? sx[2*s]     : sx[2*s+1];
        src[2*s]   = cr ? ssrc[2*s+1] : ssrc[2*s];
        src[2*s+1] = cr ? ssrc[2*s]   : ssrc[2*s+1];
      end
    end
    for (int i = 0; i < PORTS; i++) begin
      if (v[i]) dlv_data[i*DW +: DW] = x[i];
      if (v[i]) a_r1_lands_on_dest: assert (d[i] == SB'(i) && req_valid[src[i]]);
    end
    dlv_valid   = v;
    req_blocked = blk;
    a_r5_blocked_only_if_valid: assert ((blk & ~req_valid) == '0);
    a_r5_conserved: assert ($countones(v) + $countones(blk) == $countones(req_valid));
    if ($countones(req_valid) == 1) a_r8_lone_delivered: assert (blk == '0);
    if (req_valid == '0) a_r10_idle_pass: assert (sw_cross == '0 && v == '0);
  end

endmodule

// File: tb/omega_route_test.sv
module omega_route_test;
  localparam int N = 8, SB = 3, DW = 16, H = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]    rv;
  logic [N*SB-1:0] rd;
  logic [N*DW-1:0] rx;
  logic [N-1:0]    dv, blk;
  logic [N*DW-1:0] dx;
  logic [SB*H-1:0] cx;
  int vectors = 0, miss = 0;
  bit done = 0;

  omega_route #(.PORTS(N), .DW(DW)) uut (
    .req_valid(rv), .req_dest(rd), .req_data(rx),
    .dlv_valid(dv), .dlv_data(dx), .req_blocked(blk), .sw_cross(cx)
  );

  task automatic check(input string tag);
    logic [N-1:0] ev, eb;
    logic [N*DW-1:0] ex;
    logic [SB*H-1:0] ec;
    int pos[N], sh[N];
    bit live[N], lose[N], want[N];
    ev = '0; eb = '0; ex = '0; ec = '0;
    for (int m = 0; m < N; m++) begin live[m] = rv[m]; pos[m] = m; end
    for (int k = 0; k < SB; k++) begin
      for (int m = 0; m < N; m++) begin
        sh[m]   = ((pos[m] << 1) | (pos[m] >> (SB - 1))) % N;
        want[m] = rd[m*SB + SB - 1 - k];
        lose[m] = 0;
      end
      for (int m = 0; m < N; m++)
        for (int o = 0; o < N; o++)
          if (live[m] && live[o] && o != m && (sh[m] / 2 == sh[o] / 2)
              && want[m] == want[o] && sh[m] % 2 == 1) lose[m] = 1;
      for (int s = 0; s < H; s++) begin
        bit got = 0;
        for (int m = 0; m < N; m++)
          if (live[m] && sh[m] == 2*s) begin ec[k*H+s] = want[m]; got = 1; end
        if (!got)
          for (int m = 0; m < N; m++)
            if (live[m] && sh[m] == 2*s+1) ec[k*H+s] = !want[m];
      end
      for (int m = 0; m < N; m++)
        if (live[m]) begin
          if (lose[m]) begin live[m] = 0; eb[m] = 1; end
          else pos[m] = (sh[m] / 2) * 2 + int'(want[m]);
        end
    end
    for (int m = 0; m < N; m++)
      if (live[m]) begin ev[pos[m]] = 1; ex[pos[m]*DW +: DW] = rx[m*DW +: DW]; end
    vectors++;
    if (dv !== ev || blk !== eb || cx !== ec || dx !== ex) begin
      miss++;
      $display("FAIL %s: valid %h exp %h, blocked %h exp %h, cross %h exp %h, data %h exp %h",
               tag, dv, ev, blk, eb, cx, ec, dx, ex);
    end
  endtask

  task automatic apply(input logic [N-1:0] v, input logic [N*SB-1:0] d, input string tag);
    @(negedge clk);
    rv = v; rd = d;
    for (int i = 0; i < N; i++) rx[i*DW +: DW] = DW'($urandom);
    #2 check(tag);
  endtask

  initial begin
    logic [N*SB-1:0] dd;
    void'($urandom(32'd2024));
    rv = '0; rd = '0; rx = '0;
    apply('0, '0, "R10 idle");
    dd = '0; dd[2*SB +: SB] = 3'd7; dd[6*SB +: SB] = 3'd4;
    apply(8'b0100_0100, dd, "R7 collision pair");
    if (blk !== 8'b0100_0000 || dv !== 8'b1000_0000) begin
      miss++; $display("FAIL R7: blocked %h exp 40, valid %h exp 80", blk, dv);
    end
    vectors++;
    dd = '0; dd[0 +: SB] = 3'd0; dd[4*SB +: SB] = 3'd1;
    apply(8'b0001_0001, dd, "R4 upper wins");
    if (blk !== 8'b0001_0000) begin
      miss++; $display("FAIL R4: blocked %h exp 10", blk);
    end
    vectors++;
    for (int s = 0; s < N; s++)
      for (int t = 0; t < N; t++) begin
        dd = '0; dd[s*SB +: SB] = SB'(t);
        apply(N'(1) << s, dd, "R8 R1 R3 lone");
      end
    for (int c = 0; c < N; c++) begin
      for (int i = 0; i < N; i++) dd[i*SB +: SB] = SB'((i + c) % N);
      apply('1, dd, "R9 shift");
      if (blk !== '0) begin
        miss++; $display("FAIL R9: blocked %h exp 00", blk);
      end
      vectors++;
    end
    for (int n = 0; n < 600; n++)
      apply(N'($urandom), (N*SB)'($urandom), "R1 R2 R3 R4 R5 R6 random");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: finished 0 exp 1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule